// File: doc/BRIEF.md
# Display raster timing generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a parallel RGB panel, together with the pixel coordinates inside the active window. It runs on the pixel clock. All of its timing comes from registers that a host writes through a simple write-only port. Pixel data for the presented coordinate enters on `pix_data_i` and leaves on `rgb_o`. When blanking is enabled, a programmed background colour replaces that pixel data.

Host writes land in shadow copies. A write of any value to the commit address arms a transfer of every shadow field into the working set. The transfer happens at the end of the current frame, just before the counters return to the start of vertical sync. Three sticky interrupt flags are provided: frame start, line start and a programmable scan line. Each flag has a mask bit and a write-one-to-clear bit. A standby control parks the raster and silences every output.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal counter runs from 0 to the total field of register 0 (bits 27:16, the last count of a line). Hsync is active while the counter is below the sync-end field (register 0, bits 11:0), so each line lasts total+1 clocks.
- R2: The vertical counter advances once per completed line and runs from 0 to the total field of register 2 (bits 27:16). Vsync is active while the line count is below register 2 bits 11:0.
- R3: Data enable is active when the horizontal count is in [start, end) of register 1 and the line count is in [start, end) of register 3 (start in bits 11:0, end in bits 27:16). `pix_x_o` and `pix_y_o` give the counts minus the respective start values.
- R4: Writes to registers 0 to 6 change only shadow copies. Output timing is unchanged until a write to register 7 (commit).
- R5: A commit takes effect at the next frame wrap, so a frame in progress keeps its old timing. While standby is in effect, a commit takes effect on the next clock.
- R6: Register 4 bits 2, 3, 4 and 5 invert hsync, vsync, data enable and the `dclk_inv_o` flag respectively.
- R7: With register 4 bit 1 set, active pixels show the background colour (register 5, bits 23:0, black after reset) instead of `pix_data_i`. Outside the active window `rgb_o` is 0.
- R8: Register 4 bit 0 (standby, set after reset) holds both counters at 0, keeps hsync, vsync and data enable at their inactive levels and raises no interrupt event.
- R9: Flag bit 0 sets at count (0,0), bit 1 at every horizontal count 0, and bit 2 at horizontal count 0 of the line given by register 6 bits 27:16. Flags stay set until cleared.
- R10: Register 6 bits 2:0 are mask bits (1 = masked; all masked after reset). `irq_o` is high when any set flag is unmasked.
- R11: Writing 1 to register 6 bits 6:4 clears the matching flag at once, without a commit. A new event in the same cycle wins over the clear.
- R12: After reset, all sync, enable, colour, flag and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register index 0..7 |
| reg_wdata | input | DATA_W | Register write data |
| pix_data_i | input | RGB_W | Pixel for the presented coordinate |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| dclk_inv_o | output | 1 | Pixel clock inversion request |
| pix_x_o | output | CNT_W | Column inside the active window |
| pix_y_o | output | CNT_W | Row inside the active window |
| rgb_o | output | RGB_W | Output colour |
| irq_flags_o | output | 3 | Sticky flags: frame, line, scan line |
| irq_o | output | 1 | Combined unmasked interrupt |

## Verification
The bound checker covers the properties that hold every cycle. These are the horizontal wrap at the programmed total, data enable appearing only inside the window that was in force one cycle earlier, working timing staying frozen except on an applied commit, and standby parking the counters. It also checks that flags stay set until cleared, that a clear without a competing event takes effect, and that no interrupt is raised with all flags clear. Other properties can only be shown by the bench's scenarios, because they need whole frames of activity. These are the per-frame totals of sync and enable clocks for several geometries, the deferral of a commit until the frame ends, the scan-line position, and the effect of polarity, blanking and background colour on the pins.

// File: rtl/raster_pkg.sv
package raster_pkg;
  parameter int unsigned CNT_W   = 12;
  localparam int unsigned NUM_IRQ = 3;

  // flag order
  localparam int unsigned IRQ_FRAME = 0;
  localparam int unsigned IRQ_LINE  = 1;
  localparam int unsigned IRQ_SCAN  = 2;

  // register indices
  localparam int unsigned REG_HSYNC  = 0;
  localparam int unsigned REG_HACT   = 1;
  localparam int unsigned REG_VSYNC  = 2;
  localparam int unsigned REG_VACT   = 3;
  localparam int unsigned REG_CTRL   = 4;
  localparam int unsigned REG_BG     = 5;
  localparam int unsigned REG_IRQ    = 6;
  localparam int unsigned REG_COMMIT = 7;

  // field positions
  localparam int unsigned LO_POS  = 0;
  localparam int unsigned HI_POS  = 16;
  localparam int unsigned CLR_POS = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t sync_end;
    cnt_t total;
    cnt_t act_start;
    cnt_t act_end;
  } axis_t;

  typedef struct packed {
    logic clk_inv;
    logic de_inv;
    logic vs_inv;
    logic hs_inv;
    logic blank;
    logic standby;
  } ctrl_t;
endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RGB_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               frame_end_i,
  output axis_t              h_o,
  output axis_t              v_o,
  output ctrl_t              ctrl_o,
  output logic [RGB_W-1:0]   bg_o,
  output logic [NUM_IRQ-1:0] mask_o,
  output cnt_t               scan_o,
  output logic [NUM_IRQ-1:0] clr_o,
  output logic               apply_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic unused_bits;
  assign unused_bits = ^wr_data;

  logic hit_ctrl, hit_bg, hit_irq, hit_commit;
  assign hit_ctrl   = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
  assign hit_bg     = wr_en && (wr_addr == ADDR_W'(REG_BG));
  assign hit_irq    = wr_en && (wr_addr == ADDR_W'(REG_IRQ));
  assign hit_commit = wr_en && (wr_addr == ADDR_W'(REG_COMMIT));

  // commit bookkeeping
  logic  pend_q, pend_n, apply;
  ctrl_t ctrl_sh_q, ctrl_sh_n, ctrl_act_q;

  assign apply = pend_q && (frame_end_i || ctrl_act_q.standby);

  always_comb begin
    pend_n = pend_q;
    if (apply)      pend_n = 1'b0;
    if (hit_commit) pend_n = 1'b1;
  end

  // per-axis shadow and working copies
  for (genvar a = 0; a < 2; a++) begin : g_axis
    localparam logic [ADDR_W-1:0] A_SYNC = ADDR_W'(2 * a);
    localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(2 * a + 1);
    axis_t sh_q, sh_n, act_q;

    always_comb begin
      sh_n = sh_q;
      if (wr_en && wr_addr == A_SYNC) begin
        sh_n.sync_end = wr_data[LO_POS +: CNT_W];
        sh_n.total    = wr_data[HI_POS +: CNT_W];
      end
      if (wr_en && wr_addr == A_ACT) begin
        sh_n.act_start = wr_data[LO_POS +: CNT_W];
        sh_n.act_end   = wr_data[HI_POS +: CNT_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        sh_q <= sh_n;
        if (apply) act_q <= sh_q;
      end
    end
  end

  assign h_o = g_axis[0].act_q;
  assign v_o = g_axis[1].act_q;

  // control, colour and interrupt-control shadows
  logic [RGB_W-1:0]   bg_sh_q, bg_sh_n, bg_act_q;
  logic [NUM_IRQ-1:0] mask_sh_q, mask_sh_n, mask_act_q;
  cnt_t               scan_sh_q, scan_sh_n, scan_act_q;

  always_comb begin
    ctrl_sh_n = ctrl_sh_q;
    bg_sh_n   = bg_sh_q;
    mask_sh_n = mask_sh_q;
    scan_sh_n = scan_sh_q;
    if (hit_ctrl) ctrl_sh_n = ctrl_t'(wr_data[CTRL_W-1:0]);
    if (hit_bg)   bg_sh_n   = wr_data[RGB_W-1:0];
    if (hit_irq) begin
      mask_sh_n = wr_data[NUM_IRQ-1:0];
      scan_sh_n = wr_data[HI_POS +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      ctrl_sh_q  <= '{standby: 1'b1, default: 1'b0};
      ctrl_act_q <= '{standby: 1'b1, default: 1'b0};
      bg_sh_q    <= '0;
      bg_act_q   <= '0;
      mask_sh_q  <= '1;
      mask_act_q <= '1;
      scan_sh_q  <= '0;
      scan_act_q <= '0;
    end else begin
      pend_q    <= pend_n;
      ctrl_sh_q <= ctrl_sh_n;
      bg_sh_q   <= bg_sh_n;
      mask_sh_q <= mask_sh_n;
      scan_sh_q <= scan_sh_n;
      if (apply) begin
        ctrl_act_q <= ctrl_sh_q;
        bg_act_q   <= bg_sh_q;
        mask_act_q <= mask_sh_q;
        scan_act_q <= scan_sh_q;
      end
    end
  end

  assign ctrl_o  = ctrl_act_q;
  assign bg_o    = bg_act_q;
  assign mask_o  = mask_act_q;
  assign scan_o  = scan_act_q;
  assign clr_o   = hit_irq ? wr_data[CLR_POS +: NUM_IRQ] : '0;
  assign apply_o = apply;
endmodule

// File: rtl/raster_scan.sv
module raster_scan
  import raster_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_i,
  input  axis_t h_i,
  input  axis_t v_i,
  output cnt_t  hcnt_o,
  output cnt_t  vcnt_o,
  output logic  frame_end_o
);
  cnt_t hcnt_q, hcnt_n, vcnt_q, vcnt_n;
  logic line_last, frame_last;

  assign line_last  = (hcnt_q >= h_i.total);
  assign frame_last = line_last && (vcnt_q >= v_i.total);

  always_comb begin
    hcnt_n = hcnt_q;
    vcnt_n = vcnt_q;
    if (!run_i) begin
      hcnt_n = '0;
      vcnt_n = '0;
    end else if (line_last) begin
      hcnt_n = '0;
      vcnt_n = frame_last ? '0 : vcnt_q + 1'b1;
    end else begin
      hcnt_n = hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else begin
      hcnt_q <= hcnt_n;
      vcnt_q <= vcnt_n;
    end
  end

  assign hcnt_o      = hcnt_q;
  assign vcnt_o      = vcnt_q;
  assign frame_end_o = run_i && frame_last;
endmodule

// File: rtl/raster_out.sv
module raster_out
  import raster_pkg::*;
#(
  parameter int unsigned RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  cnt_t             hcnt_i,
  input  cnt_t             vcnt_i,
  input  axis_t            h_i,
  input  axis_t            v_i,
  input  ctrl_t            ctrl_i,
  input  logic [RGB_W-1:0] bg_i,
  input  logic [RGB_W-1:0] pix_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             dclk_inv_o,
  output cnt_t             x_o,
  output cnt_t             y_o,
  output logic [RGB_W-1:0] rgb_o,
  output logic             de_raw_o
);
  logic hs_q, hs_n, vs_q, vs_n, de_q, de_n;
  cnt_t x_q, x_n, y_q, y_n;
  logic h_in, v_in;

  assign h_in = (hcnt_i >= h_i.act_start) && (hcnt_i < h_i.act_end);
  assign v_in = (vcnt_i >= v_i.act_start) && (vcnt_i < v_i.act_end);

  always_comb begin
    hs_n = run_i && (hcnt_i < h_i.sync_end);
    vs_n = run_i && (vcnt_i < v_i.sync_end);
    de_n = run_i && h_in && v_in;
    x_n  = hcnt_i - h_i.act_start;
    y_n  = vcnt_i - v_i.act_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      de_q <= 1'b0;
      x_q  <= '0;
      y_q  <= '0;
    end else begin
      hs_q <= hs_n;
      vs_q <= vs_n;
      de_q <= de_n;
      x_q  <= x_n;
      y_q  <= y_n;
    end
  end

  assign hsync_o    = hs_q ^ ctrl_i.hs_inv;
  assign vsync_o    = vs_q ^ ctrl_i.vs_inv;
  assign de_o       = de_q ^ ctrl_i.de_inv;
  assign dclk_inv_o = ctrl_i.clk_inv;
  assign x_o        = x_q;
  assign y_o        = y_q;
  assign rgb_o      = de_q ? (ctrl_i.blank ? bg_i : pix_i) : '0;
  assign de_raw_o   = de_q;
endmodule

// File: rtl/raster_irq.sv
module raster_irq
  import raster_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  cnt_t               hcnt_i,
  input  cnt_t               vcnt_i,
  input  cnt_t               scan_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  output logic [NUM_IRQ-1:0] flags_o,
  output logic [NUM_IRQ-1:0] ev_o,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] ev;
  logic               at_line_head;

  assign at_line_head = run_i && (hcnt_i == '0);

  always_comb begin
    ev            = '0;
    ev[IRQ_FRAME] = at_line_head && (vcnt_i == '0);
    ev[IRQ_LINE]  = at_line_head;
    ev[IRQ_SCAN]  = at_line_head && (vcnt_i == scan_i);
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_flag
    logic flag_q, flag_n;
    always_comb flag_n = ev[i] || (flag_q && !clr_i[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_n;
    end
    assign flags_o[i] = flag_q;
  end

  assign ev_o  = ev;
  assign irq_o = |(flags_o & ~mask_i);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RGB_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [RGB_W-1:0]   pix_data_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic               dclk_inv_o,
  output logic [CNT_W-1:0]   pix_x_o,
  output logic [CNT_W-1:0]   pix_y_o,
  output logic [RGB_W-1:0]   rgb_o,
  output logic [NUM_IRQ-1:0] irq_flags_o,
  output logic               irq_o
);
  axis_t              h_act, v_act;
  ctrl_t              ctrl_act;
  logic [RGB_W-1:0]   bg_act;
  logic [NUM_IRQ-1:0] mask_act, irq_clr, irq_ev;
  cnt_t               scan_act, hcnt, vcnt;
  logic               frame_end, apply, run, de_raw;

  assign run = !ctrl_act.standby;

  raster_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RGB_W(RGB_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .frame_end_i(frame_end),
    .h_o(h_act), .v_o(v_act), .ctrl_o(ctrl_act), .bg_o(bg_act),
    .mask_o(mask_act), .scan_o(scan_act), .clr_o(irq_clr), .apply_o(apply)
  );

  raster_scan u_scan (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .h_i(h_act), .v_i(v_act),
    .hcnt_o(hcnt), .vcnt_o(vcnt), .frame_end_o(frame_end)
  );

  raster_out #(.RGB_W(RGB_W)) u_out (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .hcnt_i(hcnt), .vcnt_i(vcnt), .h_i(h_act), .v_i(v_act),
    .ctrl_i(ctrl_act), .bg_i(bg_act), .pix_i(pix_data_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .dclk_inv_o(dclk_inv_o),
    .x_o(pix_x_o), .y_o(pix_y_o), .rgb_o(rgb_o), .de_raw_o(de_raw)
  );

  raster_irq u_irq (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .hcnt_i(hcnt), .vcnt_i(vcnt), .scan_i(scan_act),
    .mask_i(mask_act), .clr_i(irq_clr),
    .flags_o(irq_flags_o), .ev_o(irq_ev), .irq_o(irq_o)
  );
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
  import raster_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input cnt_t               hcnt,
  input cnt_t               vcnt,
  input axis_t              h,
  input axis_t              v,
  input logic               apply,
  input logic               de_raw,
  input logic [NUM_IRQ-1:0] flags,
  input logic [NUM_IRQ-1:0] ev,
  input logic [NUM_IRQ-1:0] clr,
  input logic               irq
);
  // R1
  hwrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hcnt == h.total) |=> (hcnt == '0));

  // R3
  de_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> ($past(hcnt) >= $past(h.act_start) && $past(hcnt) < $past(h.act_end) &&
                $past(vcnt) >= $past(v.act_start) && $past(vcnt) < $past(v.act_end)));

  // R5
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(h) && $stable(v)));

  // R8
  standby_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!de_raw && hcnt == '0 && vcnt == '0));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~ev)) |=> ((flags & $past(clr & ~ev)) == '0));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);
endmodule

bind raster_timing_gen raster_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .hcnt(hcnt), .vcnt(vcnt),
  .h(h_act), .v(v_act), .apply(apply), .de_raw(de_raw),
  .flags(irq_flags_o), .ev(irq_ev), .clr(irq_clr), .irq(irq_o)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 3;
  // hs_end, htot, hact_s, hact_e, vs_end, vtot, vact_s, vact_e, exp_de, exp_hs, exp_vs
  localparam int unsigned VEC [NVEC][11] = '{
    '{2, 19, 4, 16, 1,  9, 2,  8,  72, 20, 20},
    '{3, 29, 5, 25, 2, 11, 3, 10, 140, 36, 60},
    '{1, 11, 2, 10, 1,  5, 1,  5,  32,  6, 12}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [23:0] pix_data_i;
  logic        hsync_o, vsync_o, de_o, dclk_inv_o, irq_o;
  logic [11:0] pix_x_o, pix_y_o;
  logic [23:0] rgb_o;
  logic [2:0]  irq_flags_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cur_mask = 7;
  int cur_scan = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pix_data_i(pix_data_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .dclk_inv_o(dclk_inv_o),
    .pix_x_o(pix_x_o), .pix_y_o(pix_y_o), .rgb_o(rgb_o),
    .irq_flags_o(irq_flags_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr  = a[2:0];
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic irq_cfg(input int mask, input int scan, input int clr);
    cur_mask = mask;
    cur_scan = scan;
    wr(6, (scan << 16) | (clr << 4) | mask);
  endtask

  task automatic clear(input int bits);
    irq_cfg(cur_mask, cur_scan, bits);
  endtask

  task automatic wait_flag(input int b);
    while (!irq_flags_o[b]) @(negedge clk);
  endtask

  task automatic commit_sync();
    wr(7, 0);
    clear(1);
    wait_flag(0);
  endtask

  task automatic measure(input int n, output int de_c, output int hs_c, output int vs_c);
    de_c = 0; hs_c = 0; vs_c = 0;
    for (int i = 0; i < n; i++) begin
      de_c += int'(de_o);
      hs_c += int'(hsync_o);
      vs_c += int'(vsync_o);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int de_c, hs_c, vs_c;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    pix_data_i = 24'h123456;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset state
    chk("R12 hsync", hsync_o, 0);
    chk("R12 vsync", vsync_o, 0);
    chk("R12 de", de_o, 0);
    chk("R12 rgb", rgb_o, 0);
    chk("R12 flags", irq_flags_o, 0);
    chk("R12 irq", irq_o, 0);
    // R8 standby after reset: nothing moves
    measure(50, de_c, hs_c, vs_c);
    chk("R8 reset standby de", de_c, 0);
    chk("R8 reset standby flags", irq_flags_o, 0);

    // table of geometries
    for (int k = 0; k < NVEC; k++) begin
      irq_cfg(7, 0, 0);
      wr(0, (VEC[k][1] << 16) | VEC[k][0]);
      wr(1, (VEC[k][3] << 16) | VEC[k][2]);
      wr(2, (VEC[k][5] << 16) | VEC[k][4]);
      wr(3, (VEC[k][7] << 16) | VEC[k][6]);
      wr(4, 0);
      commit_sync();
      chk("R1 hsync at frame head", hsync_o, 1);
      chk("R2 vsync at frame head", vsync_o, 1);
      measure((VEC[k][1] + 1) * (VEC[k][5] + 1), de_c, hs_c, vs_c);
      chk("R3 de clocks per frame", de_c, VEC[k][8]);
      chk("R1 hsync clocks per frame", hs_c, VEC[k][9]);
      chk("R2 vsync clocks per frame", vs_c, VEC[k][10]);
      chk("R10 masked flags give no irq", irq_o, 0);
    end

    // R4: shadow write without commit leaves timing alone (config 2 running)
    wr(0, (11 << 16) | 5);
    clear(1);
    wait_flag(0);
    measure(72, de_c, hs_c, vs_c);
    chk("R4 uncommitted hsync unchanged", hs_c, 6);

    // R5: commit mid-frame waits for the frame end
    clear(1);
    wait_flag(0);
    wr(7, 0);
    clear(2);
    wait_flag(1);
    measure(12, de_c, hs_c, vs_c);
    chk("R5 old timing in current frame", hs_c, 1);
    clear(1);
    wait_flag(0);
    measure(12, de_c, hs_c, vs_c);
    chk("R5 new timing next frame", hs_c, 5);

    // R3 coordinates
    clear(1);
    wait_flag(0);
    while (!de_o) @(negedge clk);
    chk("R3 first x", pix_x_o, 0);
    chk("R3 first y", pix_y_o, 0);
    @(negedge clk);
    chk("R3 second x", pix_x_o, 1);

    // R9/R10 scan line 4, only scan unmasked
    irq_cfg(3, 4, 0);
    commit_sync();
    clear(4);
    wait_flag(2);
    chk("R9 scan line row", pix_y_o, 3);
    chk("R10 unmasked scan raises irq", irq_o, 1);
    clear(4);
    chk("R11 scan flag cleared", irq_flags_o[2], 0);
    chk("R11 irq drops after clear", irq_o, 0);

    // R6 polarity
    wr(4, 32'h3C);
    commit_sync();
    chk("R6 hsync inverted at frame head", hsync_o, 0);
    chk("R6 dclk inversion", dclk_inv_o, 1);
    measure(72, de_c, hs_c, vs_c);
    chk("R6 inverted hsync clocks", hs_c, 42);
    chk("R6 inverted vsync clocks", vs_c, 60);
    chk("R6 inverted de clocks", de_c, 40);

    // R7 blanking and background
    wr(4, 2);
    commit_sync();
    chk("R7 rgb zero outside window", rgb_o, 0);
    while (!de_o) @(negedge clk);
    chk("R7 background black after reset", rgb_o, 0);
    wr(5, 32'h00ABCD);
    commit_sync();
    while (!de_o) @(negedge clk);
    chk("R7 background colour shown", rgb_o, 24'h00ABCD);
    wr(4, 0);
    commit_sync();
    while (!de_o) @(negedge clk);
    chk("R7 pixel passes when not blanked", rgb_o, 24'h123456);

    // R8 standby entered while running
    wr(4, 1);
    wr(7, 0);
    repeat (100) @(negedge clk);
    clear(7);
    measure(100, de_c, hs_c, vs_c);
    chk("R8 standby de", de_c, 0);
    chk("R8 standby hsync", hs_c, 0);
    chk("R8 standby vsync", vs_c, 0);
    chk("R8 standby no events", irq_flags_o, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule